// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This unit works out where instruction fetch goes after the current instruction. The stream is 32-bit and word-aligned. The unit takes the current program counter, the 6-bit opcode, the 5-bit rt selector, the 16-bit branch offset and the 26-bit jump index. It also takes the two register operands the branch compares, called A (the rs value) and B (the rt value). From these it produces the following address and a flag that is high when control leaves the sequential path.

Six opcodes change the path:

- Opcode 2 is an absolute jump within the current 256 MB region.
- Opcodes 4 and 5 compare the two operands for equality or inequality.
- Opcodes 6 and 7 test operand A against zero as a signed value.
- Opcode 1 also tests A against zero. Its direction is picked by the rt selector.

All other opcodes, and every branch whose condition fails, continue at the next word.

The decision is worked out in one combinational stage. The result is captured in a register on the clock edge, so it appears one cycle after the inputs are sampled. The surrounding pipeline can then use it as a clean, registered fetch address.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, npc_o is 0 and taken_o is 0. rst_n acts asynchronously and holds the outputs there even while the inputs present a taken jump.
- R2: Inputs sampled at a rising clock edge set npc_o and taken_o right after that edge. Between edges the outputs do not change, whatever the inputs do.
- R3: Opcode 2 (jump) always sets taken_o. npc_o takes bits [31:28] from pc_i, bits [27:2] from jidx_i, and zero in bits [1:0].
- R4: Opcode 4 is taken when opa_i equals opb_i. Opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when opa_i, read as signed, is at most zero. Opcode 7 is taken when opa_i, read as signed, is above zero. 0x80000000 counts as negative for both.
- R6: Opcode 1 with rt_sel_i = 0 is taken when opa_i is negative. With rt_sel_i = 1 it is taken when opa_i is zero or positive. Any other rt_sel_i value is never taken.
- R7: A taken branch sets npc_o to pc_i + 4 + 4 × (sign-extended boff_i). Examples: from address 8, offset 2 gives 20; from address 16, offset 0xFFFC gives 4. Offsets 0x8000 and 0x7FFF reach the two extremes.
- R8: An untaken branch, and any opcode other than 1, 2, 4, 5, 6 or 7, sets npc_o to pc_i + 4 with taken_o low.
- R9: npc_o[1:0] is always 00, even when pc_i[1:0] is not zero.
- R10: The address sums wrap modulo 2^32. For example, pc_i = 0xFFFFFFFC with a sequential opcode gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Primary opcode field |
| rt_sel_i | input | 5 | rt field; picks the direction for opcode 1 |
| boff_i | input | 16 | Signed branch offset, in words |
| jidx_i | input | 26 | Jump word index |
| opa_i | input | 32 | Operand A (rs value) for the compare |
| opb_i | input | 32 | Operand B (rt value) for the equality compare |
| npc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Registered flag: branch or jump taken |

## Verification
Every result is due exactly one rising edge after its inputs are sampled. The bench therefore changes the inputs on a falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. A separate latency test changes the inputs again and reads the outputs before the next rising edge, to show they still hold the earlier result. The reset checks are the one exception to the one-edge rule: they read one time step after rst_n falls, because the clear acts without waiting for a clock edge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Opcode values; the position and meaning of each is fixed by the instruction encoding.
    localparam logic [5:0] OP_ZCMP = 6'd1;  // compare A with zero, direction from rt
    localparam logic [5:0] OP_JMP  = 6'd2;
    localparam logic [5:0] OP_EQ   = 6'd4;
    localparam logic [5:0] OP_NE   = 6'd5;
    localparam logic [5:0] OP_LEZ  = 6'd6;
    localparam logic [5:0] OP_GTZ  = 6'd7;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_EQ,
        CK_NE,
        CK_LEZ,
        CK_GTZ,
        CK_LTZ,
        CK_GEZ,
        CK_ALWAYS
    } cond_kind_e;

    function automatic cond_kind_e decode_cond(input logic [5:0] opc, input logic [4:0] rt);
        cond_kind_e k;
        k = CK_NONE;
        case (opc)
            OP_JMP:  k = CK_ALWAYS;
            OP_EQ:   k = CK_EQ;
            OP_NE:   k = CK_NE;
            OP_LEZ:  k = CK_LEZ;
            OP_GTZ:  k = CK_GTZ;
            OP_ZCMP: begin
                if (rt == 5'd0)      k = CK_LTZ;
                else if (rt == 5'd1) k = CK_GEZ;
                else                 k = CK_NONE;
            end
            default: k = CK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OPC_W = 6,
    parameter int RT_W = 5
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [RT_W-1:0]  rt_sel_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic             hit_o,
    output logic             jump_o
);

    cond_kind_e kind;
    logic       a_neg;
    logic       a_zero;
    logic       same;

    always_comb begin
        kind   = decode_cond(opcode_i, rt_sel_i);
        a_neg  = opa_i[XLEN-1];
        a_zero = (opa_i == '0);
        same   = (opa_i == opb_i);
        jump_o = (kind == CK_ALWAYS);
        case (kind)
            CK_ALWAYS: hit_o = 1'b1;
            CK_EQ:     hit_o = same;
            CK_NE:     hit_o = !same;
            CK_LEZ:    hit_o = a_neg || a_zero;
            CK_GTZ:    hit_o = !a_neg && !a_zero;
            CK_LTZ:    hit_o = a_neg;
            CK_GEZ:    hit_o = !a_neg;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] boff_i,
    input  logic [IDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  br_o,
    output logic [XLEN-1:0]  jmp_o
);

    localparam int EXT_W  = XLEN - OFF_W - 2;
    localparam int KEEP_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] step;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] seq_raw;
    logic [XLEN-1:0] br_raw;

    always_comb begin
        step    = XLEN'(4);
        disp    = {{EXT_W{boff_i[OFF_W-1]}}, boff_i, 2'b00};
        seq_raw = pc_i + step;
        br_raw  = seq_raw + disp;
        seq_o   = {seq_raw[XLEN-1:2], 2'b00};
        br_o    = {br_raw[XLEN-1:2], 2'b00};
    end

    generate
        if (KEEP_W > 0) begin : g_region
            assign jmp_o = {pc_i[XLEN-1 -: KEEP_W], jidx_i, 2'b00};
        end else begin : g_flat
            assign jmp_o = XLEN'({jidx_i, 2'b00});
        end
    endgenerate

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int XLEN  = 32,
    parameter int OPC_W = 6,
    parameter int RT_W  = 5,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [RT_W-1:0]  rt_sel_i,
    input  logic [OFF_W-1:0] boff_i,
    input  logic [IDX_W-1:0] jidx_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic [XLEN-1:0]  npc_o,
    output logic             taken_o
);

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            taken;
    } npc_state_t;

    npc_state_t      st_d;
    npc_state_t      st_q;
    logic            hit;
    logic            is_jump;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    npc_cond_eval #(
        .XLEN (XLEN),
        .OPC_W(OPC_W),
        .RT_W (RT_W)
    ) u_cond (
        .opcode_i(opcode_i),
        .rt_sel_i(rt_sel_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .hit_o   (hit),
        .jump_o  (is_jump)
    );

    npc_target_gen #(
        .XLEN (XLEN),
        .OFF_W(OFF_W),
        .IDX_W(IDX_W)
    ) u_tgt (
        .pc_i  (pc_i),
        .boff_i(boff_i),
        .jidx_i(jidx_i),
        .seq_o (seq_pc),
        .br_o  (br_pc),
        .jmp_o (jmp_pc)
    );

    always_comb begin
        st_d.taken = hit;
        if (is_jump)  st_d.addr = jmp_pc;
        else if (hit) st_d.addr = br_pc;
        else          st_d.addr = seq_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign npc_o   = st_q.addr;
    assign taken_o = st_q.taken;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_i,
    input logic [5:0]  opcode_i,
    input logic [4:0]  rt_sel_i,
    input logic [25:0] jidx_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic [31:0] npc_o,
    input logic        taken_o
);

    logic live_q;
    logic in_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q   <= 1'b0;
            in_rst_q <= 1'b1;
        end else begin
            live_q   <= 1'b1;
            in_rst_q <= 1'b0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        (in_rst_q && !rst_n) |-> (npc_o == 32'd0 && !taken_o));

    assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        npc_o[1:0] == 2'b00);

    assert_jump_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(opcode_i) == OP_JMP) |->
        (taken_o && npc_o[31:28] == $past(pc_i[31:28]) && npc_o[27:2] == $past(jidx_i)));

    assert_eq_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(opcode_i) == OP_EQ) |-> (taken_o == ($past(opa_i) == $past(opb_i))));

    assert_ne_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(opcode_i) == OP_NE) |-> (taken_o == ($past(opa_i) != $past(opb_i))));

    assert_rt_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(opcode_i) == OP_ZCMP && $past(rt_sel_i) > 5'd1) |-> !taken_o);

    assert_sequential_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !taken_o) |-> (npc_o == (($past(pc_i) + 32'd4) & 32'hFFFF_FFFC)));

endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_i    (pc_i),
    .opcode_i(opcode_i),
    .rt_sel_i(rt_sel_i),
    .jidx_i  (jidx_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .npc_o   (npc_o),
    .taken_o (taken_o)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;

    typedef struct packed {
        logic [31:0] pc;
        logic [5:0]  op;
        logic [4:0]  rt;
        logic [15:0] off;
        logic [25:0] idx;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_pc;
        logic        exp_tk;
        logic [7:0]  req;
    } vec_t;

    // pc, op, rt, off, idx, a, b, expected npc, expected taken, requirement number
    localparam vec_t TBL [NVEC] = '{
        '{32'h8,        6'd4, 5'd0,  16'h0002, 26'h0,       32'd5,        32'd5, 32'd20,       1'b1, 8'd7},  // R7 example 1
        '{32'h10,       6'd5, 5'd0,  16'hFFFC, 26'h0,       32'd1,        32'd2, 32'd4,        1'b1, 8'd7},  // R7 example 2
        '{32'h100,      6'd4, 5'd0,  16'h0008, 26'h0,       32'd1,        32'd2, 32'h104,      1'b0, 8'd4},  // R4 unequal
        '{32'h200,      6'd5, 5'd0,  16'h0008, 26'h0,       32'd9,        32'd9, 32'h204,      1'b0, 8'd4},  // R4 equal
        '{32'h40,       6'd6, 5'd0,  16'h0001, 26'h0,       32'd0,        32'd0, 32'h48,       1'b1, 8'd5},  // R5 lez zero
        '{32'h40,       6'd6, 5'd0,  16'h0001, 26'h0,       32'd1,        32'd0, 32'h44,       1'b0, 8'd5},  // R5 lez pos
        '{32'h40,       6'd6, 5'd0,  16'h0001, 26'h0,       32'h80000000, 32'd0, 32'h48,       1'b1, 8'd5},  // R5 lez min
        '{32'h40,       6'd7, 5'd0,  16'h0001, 26'h0,       32'h80000000, 32'd0, 32'h44,       1'b0, 8'd5},  // R5 gtz min
        '{32'h40,       6'd7, 5'd0,  16'h0001, 26'h0,       32'd1,        32'd0, 32'h48,       1'b1, 8'd5},  // R5 gtz one
        '{32'h40,       6'd7, 5'd0,  16'h0001, 26'h0,       32'd0,        32'd0, 32'h44,       1'b0, 8'd5},  // R5 gtz zero
        '{32'h1000,     6'd1, 5'd0,  16'h0010, 26'h0,       32'hFFFFFFFF, 32'd0, 32'h1044,     1'b1, 8'd6},  // R6 ltz neg
        '{32'h1000,     6'd1, 5'd0,  16'h0010, 26'h0,       32'd0,        32'd0, 32'h1004,     1'b0, 8'd6},  // R6 ltz zero
        '{32'h1000,     6'd1, 5'd1,  16'h0010, 26'h0,       32'd0,        32'd0, 32'h1044,     1'b1, 8'd6},  // R6 gez zero
        '{32'h1000,     6'd1, 5'd1,  16'h0010, 26'h0,       32'h80000000, 32'd0, 32'h1004,     1'b0, 8'd6},  // R6 gez min
        '{32'h1000,     6'd1, 5'd2,  16'h0010, 26'h0,       32'd0,        32'd0, 32'h1004,     1'b0, 8'd6},  // R6 rt=2
        '{32'h1000,     6'd1, 5'd17, 16'h0010, 26'h0,       32'hFFFFFFFF, 32'd0, 32'h1004,     1'b0, 8'd6},  // R6 rt=17
        '{32'hA0000010, 6'd2, 5'd0,  16'h0000, 26'h0123456, 32'd0,        32'd0, 32'hA048D158, 1'b1, 8'd3},  // R3 jump
        '{32'hF0000000, 6'd2, 5'd0,  16'h0000, 26'h3FFFFFF, 32'd0,        32'd0, 32'hFFFFFFFC, 1'b1, 8'd3},  // R3 jump max
        '{32'h300,      6'd0, 5'd0,  16'h0004, 26'h0,       32'd3,        32'd3, 32'h304,      1'b0, 8'd8},  // R8 op 0
        '{32'h300,      6'h23,5'd0,  16'h0004, 26'h0,       32'd3,        32'd3, 32'h304,      1'b0, 8'd8},  // R8 load op
        '{32'h500,      6'd3, 5'd0,  16'h0004, 26'h1,       32'd0,        32'd0, 32'h504,      1'b0, 8'd8},  // R8 op 3
        '{32'hFFFFFFFC, 6'd0, 5'd0,  16'h0000, 26'h0,       32'd0,        32'd0, 32'h0,        1'b0, 8'd10}, // R10 seq wrap
        '{32'hFFFFFFF8, 6'd4, 5'd0,  16'h0001, 26'h0,       32'd7,        32'd7, 32'h0,        1'b1, 8'd10}, // R10 branch wrap
        '{32'h103,      6'd0, 5'd0,  16'h0000, 26'h0,       32'd0,        32'd0, 32'h104,      1'b0, 8'd9},  // R9 seq misaligned
        '{32'hB,        6'd4, 5'd0,  16'h0002, 26'h0,       32'd4,        32'd4, 32'h14,       1'b1, 8'd9},  // R9 branch misaligned
        '{32'h40000,    6'd4, 5'd0,  16'h8000, 26'h0,       32'd0,        32'd0, 32'h20004,    1'b1, 8'd7},  // R7 most negative
        '{32'h0,        6'd4, 5'd0,  16'h7FFF, 26'h0,       32'd0,        32'd0, 32'h20000,    1'b1, 8'd7}   // R7 most positive
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] pc_i;
    logic [5:0]  opcode_i;
    logic [4:0]  rt_sel_i;
    logic [15:0] boff_i;
    logic [25:0] jidx_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [31:0] npc_o;
    logic        taken_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    npc_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_i    (pc_i),
        .opcode_i(opcode_i),
        .rt_sel_i(rt_sel_i),
        .boff_i  (boff_i),
        .jidx_i  (jidx_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .npc_o   (npc_o),
        .taken_o (taken_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got_pc, input logic got_tk,
                         input logic [31:0] exp_pc, input logic exp_tk);
        n_checks++;
        if (got_pc !== exp_pc || got_tk !== exp_tk) begin
            n_errors++;
            $display("FAIL %s: npc=%h taken=%b, expected npc=%h taken=%b",
                     tag, got_pc, got_tk, exp_pc, exp_tk);
        end
    endtask

    task automatic apply(input vec_t v);
        pc_i     = v.pc;
        opcode_i = v.op;
        rt_sel_i = v.rt;
        boff_i   = v.off;
        jidx_i   = v.idx;
        opa_i    = v.a;
        opb_i    = v.b;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end

    initial begin
        vec_t jv;
        vec_t sv;
        rst_n = 1'b0;
        // A taken jump on the inputs during reset must not reach the outputs.
        jv = '{32'h30000000, 6'd2, 5'd0, 16'h0, 26'h0000010, 32'd0, 32'd0, 32'h30000040, 1'b1, 8'd3};
        apply(jv);
        repeat (3) @(negedge clk);
        check("R1 reset state", npc_o, taken_o, 32'd0, 1'b0);
        rst_n = 1'b1;

        // Table walk: drive on a falling edge, read on the next falling edge.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[i].req, i), npc_o, taken_o,
                  TBL[i].exp_pc, TBL[i].exp_tk);
        end

        // R2: outputs hold until the next rising edge.
        @(negedge clk);
        apply(jv);
        @(negedge clk);
        check("R2 jump result after one edge", npc_o, taken_o, 32'h30000040, 1'b1);
        sv = '{32'h600, 6'd0, 5'd0, 16'h0, 26'h0, 32'd0, 32'd0, 32'h604, 1'b0, 8'd2};
        apply(sv);
        #1;
        check("R2 output held before edge", npc_o, taken_o, 32'h30000040, 1'b1);
        @(negedge clk);
        check("R2 new result after edge", npc_o, taken_o, 32'h604, 1'b0);

        // R1: asynchronous reset during operation with a taken jump presented.
        apply(jv);
        @(negedge clk);
        check("R1 pre-reset jump", npc_o, taken_o, 32'h30000040, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", npc_o, taken_o, 32'd0, 1'b0);
        @(negedge clk);
        check("R1 held in reset", npc_o, taken_o, 32'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resume after reset", npc_o, taken_o, 32'h30000040, 1'b1);

        done = 1;
        finish_run();
    end

endmodule